// File: doc/BRIEF.md
# Raw Event Frame Builder

This block turns one trigger into one readout event and writes that event into a downstream output FIFO, one 32-bit word per cycle. Each word has an is-character flag and a write strobe. The block waits until a trigger record and an error record are both available. It pops both records together. From them it chooses one of four event shapes:

- **Full read.** Every channel is drained when a privilege flag or an external read-all input forces it.
- **Selective read.** Only channels that are marked in error and also enabled are drained.
- **Map-only event.** If no channel is selected, the payload is the error map itself.
- **Empty event.** This is header plus trailer only. It is produced when safe mode is on and the trigger FIFO occupancy has reached a threshold.

A drained channel gives up words until its valid input drops. A short per-channel trailer then closes that channel. The event closes with a trailer word that carries the payload size and the error summary bits. The output FIFO's programmable-full flag stalls every write without losing a word. A one-cycle done pulse marks each finished event.

Top module: `raw_frame_builder`

## Requirements
- R1: After synchronous reset: `out_valid_o` is 0, `out_data_o` is 0x000000BC, `out_char_o` is 1, `frame_done_o` is 0, `state_o` is 0, and no FIFO read strobe is asserted.
- R2: The trigger and error FIFOs are popped together, in a single cycle, and only while both are non-empty and `out_full_i` is low. Otherwise the block waits in idle.
- R3: The first header word is K28.3 (0x7C) in bits 7:0, the bunch identifier (trigger bits 43:32) in bits 19:8, and trigger bits 46:44 in bits 22:20, with the char flag set. The second header word is the event identifier (trigger bits 31:0), with the char flag clear.
- R4: In normal mode, a channel is read only if its bit is set in the error map (error bits NCH-1:0) and in `ch_en_i`. Selected channels are read in ascending order. Each is drained until its valid drops, and its words pass through as the low 32 bits of its input. Each channel then ends with a trailer word: channel number in bits 5:0, the OR of the drained 4-bit error fields (input bits 35:32) in bits 11:8, and zeros elsewhere.
- R5: If no channel is selected in normal mode, the payload is two words. The first is error-map bits 31:0. The second is map bits 48:32, zero-extended.
- R6: If trigger bit 44 (privilege) or `read_all_i` is set, every channel is drained, whatever its map or enable bits say.
- R7: When `safe_en_i` is set and `trig_occ_i` is greater than or equal to `safe_thresh_i` at the start of an event, the event is two headers and the final trailer with no payload. This takes priority over forced reads. One count below the threshold gives a normal event.
- R8: The final trailer is K28.6 (0xDC) in bits 7:0, the number of words between the second header and the trailer in bits 23:8, error bits NCH+2:NCH in bits 26:24, error bit NCH+3 in bit 27 and error bit NCH+4 in bit 28. The char flag is set.
- R9: While `out_valid_o` is low, the output shows the idle character 0xBC with the char flag set. Written words carry the char flag only on the first header and the final trailer.
- R10: No word is written in the cycle after a cycle with `out_full_i` high. Under any pattern of stalls, the event word sequence is unchanged: no word is dropped or repeated.
- R11: `frame_done_o` pulses for exactly one cycle per event, in the cycle the final trailer is presented.
- R12: At most one channel read strobe is high in any cycle, and only for a channel whose valid is high. Channels that are not selected are never popped.
- R13: `state_o` reads 0 in idle, and reads a nonzero value from the cycle after the FIFO pop until the final trailer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_word_i | input | 47 | Trigger FIFO head: raw-full flag, reserved, privilege, bunch id, event id |
| trig_empty_i | input | 1 | Trigger FIFO empty |
| trig_occ_i | input | OCCW | Trigger FIFO occupancy |
| trig_rd_o | output | 1 | Trigger FIFO pop |
| err_word_i | input | NCH+5 | Error FIFO head: reserved, request flag, link error, channel map |
| err_empty_i | input | 1 | Error FIFO empty |
| err_rd_o | output | 1 | Error FIFO pop |
| ch_data_i | input | NCH*36 | Per-channel heads, 4-bit error above 32-bit data |
| ch_valid_i | input | NCH | Per-channel data available |
| ch_en_i | input | NCH | Per-channel enable for error readout |
| ch_rd_o | output | NCH | Per-channel pop |
| read_all_i | input | 1 | Force readout of every channel |
| safe_en_i | input | 1 | Safe mode enable |
| safe_thresh_i | input | OCCW | Occupancy threshold for empty events |
| out_full_i | input | 1 | Output FIFO programmable-full |
| out_data_o | output | 32 | Output word |
| out_char_o | output | 1 | Output word holds a control character |
| out_valid_o | output | 1 | Output FIFO write strobe |
| frame_done_o | output | 1 | Event finished pulse |
| state_o | output | 8 | Current controller state |

## Verification
The bench sweeps a single errored channel across all 49 positions with drain lengths of zero to three. A block that mis-scans the lowest channel or the highest channel, or that mishandles an empty channel, writes a wrong channel trailer or pops a neighbour. Enable-masked errors, privilege and read-all forcing, and the safe threshold at exactly its value and one below are each run. A mistaken precedence or an off-by-one compare changes the payload and the trailer count. Random output stalls run over long forced events, so a write issued while full, or a repeated or dropped word, breaks the compared sequence. Waits with only one FIFO ready, or with the output full, catch a block that starts early.

// File: rtl/raw_frame_pkg.sv
// Shared constants and state type for the raw event frame builder.
// Assumes 8b/10b style control codes in the low byte of a 32-bit word.
package raw_frame_pkg;

    localparam logic [7:0] K_IDLE = 8'hBC;   // K28.5
    localparam logic [7:0] K_SOP  = 8'h7C;   // K28.3
    localparam logic [7:0] K_EOP  = 8'hDC;   // K28.6

    localparam int CEW    = 4;               // error field per channel word
    localparam int CHW    = CEW + 32;        // channel word width
    localparam int TRIGW  = 47;              // trigger record width
    localparam int CNTW   = 16;              // payload counter width

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_HDR1  = 4'd1,
        ST_HDR2  = 4'd2,
        ST_MAP   = 4'd3,
        ST_SCAN  = 4'd4,
        ST_DRAIN = 4'd5,
        ST_CTRL  = 4'd6,
        ST_TRAIL = 4'd7
    } fsm_state_t;

endpackage

// File: rtl/raw_chan_pick.sv
// Lowest-index picker over the set of channels still pending.
// Assumes IW is wide enough to number NCH channels.
module raw_chan_pick #(
    parameter int NCH = 49,
    parameter int IW  = 6
) (
    input  logic [NCH-1:0] pend_i,
    output logic           any_o,
    output logic [IW-1:0]  idx_o
);

    // Find the lowest set bit; a descending loop leaves the lowest hit last.
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/raw_chan_mux.sv
// Steers the current channel's head word and valid to the controller and
// decodes the pop request into a one-hot channel read strobe.
// Assumes idx_i is always below NCH.
module raw_chan_mux #(
    parameter int NCH = 49,
    parameter int IW  = 6,
    parameter int CHW = 36
) (
    input  logic [NCH*CHW-1:0] ch_data_i,
    input  logic [NCH-1:0]     ch_valid_i,
    input  logic [IW-1:0]      idx_i,
    input  logic               pop_i,
    output logic [CHW-1:0]     sel_word_o,
    output logic               sel_valid_o,
    output logic [NCH-1:0]     rd_o
);

    logic [NCH-1:0] hit;

    // One compare per channel, shared by the data mux and the read decode.
    for (genvar g = 0; g < NCH; g++) begin : g_dec
        assign hit[g]  = (idx_i == IW'(g));
        assign rd_o[g] = pop_i & hit[g];
    end

    assign sel_valid_o = |(hit & ch_valid_i);

    // AND-OR data mux over the channel heads.
    always_comb begin
        sel_word_o = '0;
        for (int i = 0; i < NCH; i++) begin
            sel_word_o = sel_word_o | (ch_data_i[i*CHW +: CHW] & {CHW{hit[i]}});
        end
    end

endmodule

// File: rtl/raw_word_fmt.sv
// Builds the output word and its char flag for the current controller state.
// Assumes a channel number fits in 6 bits (NCH <= 64).
module raw_word_fmt
    import raw_frame_pkg::*;
#(
    parameter int IW = 6
) (
    input  fsm_state_t        st_i,
    input  logic [TRIGW-1:0]  trig_i,
    input  logic [4:0]        err_hi_i,
    input  logic [31:0]       map_word_i,
    input  logic [31:0]       chan_word_i,
    input  logic [IW-1:0]     cur_i,
    input  logic [CEW-1:0]    eacc_i,
    input  logic [CNTW-1:0]   cnt_i,
    output logic [31:0]       word_o,
    output logic              char_o
);

    // Pick the word layout for each state.
    always_comb begin
        word_o = {24'd0, K_IDLE};
        char_o = 1'b1;
        case (st_i)
            ST_HDR1: begin
                word_o = {9'd0, trig_i[46:44], trig_i[43:32], K_SOP};
                char_o = 1'b1;
            end
            ST_HDR2: begin
                word_o = trig_i[31:0];
                char_o = 1'b0;
            end
            ST_MAP: begin
                word_o = map_word_i;
                char_o = 1'b0;
            end
            ST_DRAIN: begin
                word_o = chan_word_i;
                char_o = 1'b0;
            end
            ST_CTRL: begin
                word_o = {20'd0, eacc_i, 2'd0, 6'(cur_i)};
                char_o = 1'b0;
            end
            ST_TRAIL: begin
                word_o = {3'd0, err_hi_i, cnt_i, K_EOP};
                char_o = 1'b1;
            end
            default: begin
                word_o = {24'd0, K_IDLE};
                char_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/raw_frame_builder.sv
// Raw event frame builder: pops one trigger and one error record per event,
// chooses empty, map-only, selective or full readout, drains the chosen
// channels in ascending order and writes headers, payload and trailers to
// the output FIFO. Assumes first-word-fall-through FIFOs on every input and
// NCH <= 64. Writes stall while out_full_i is high.
module raw_frame_builder
    import raw_frame_pkg::*;
#(
    parameter int NCH  = 49,
    parameter int OCCW = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [46:0]          trig_word_i,
    input  logic                 trig_empty_i,
    input  logic [OCCW-1:0]      trig_occ_i,
    output logic                 trig_rd_o,
    input  logic [NCH+4:0]       err_word_i,
    input  logic                 err_empty_i,
    output logic                 err_rd_o,
    input  logic [NCH*36-1:0]    ch_data_i,
    input  logic [NCH-1:0]       ch_valid_i,
    input  logic [NCH-1:0]       ch_en_i,
    output logic [NCH-1:0]       ch_rd_o,
    input  logic                 read_all_i,
    input  logic                 safe_en_i,
    input  logic [OCCW-1:0]      safe_thresh_i,
    input  logic                 out_full_i,
    output logic [31:0]          out_data_o,
    output logic                 out_char_o,
    output logic                 out_valid_o,
    output logic                 frame_done_o,
    output logic [7:0]           state_o
);

    localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int ERRW = NCH + 5;
    localparam int MAPN = (NCH + 31) / 32;
    localparam int MIW  = (MAPN > 1) ? $clog2(MAPN) : 1;

    fsm_state_t        st;
    logic [TRIGW-1:0]  trig_q;
    logic [ERRW-1:0]   err_q;
    logic [NCH-1:0]    pend;
    logic [IW-1:0]     cur;
    logic              safe_q;
    logic              maponly_q;
    logic [MIW-1:0]    map_i;
    logic [CNTW-1:0]   cnt;
    logic [CEW-1:0]    eacc;

    logic              start;
    logic              forced;
    logic              safe_now;
    logic [NCH-1:0]    sel_now;
    logic              pick_any;
    logic [IW-1:0]     pick_idx;
    logic [CHW-1:0]    sel_word;
    logic              sel_valid;
    logic              pop;
    logic              wr;
    logic [31:0]       fmt_word;
    logic              fmt_char;
    logic [MAPN*32-1:0] map_ext;

    // Start and mode decision, evaluated only in idle.
    always_comb begin
        start    = (st == ST_IDLE) && !trig_empty_i && !err_empty_i && !out_full_i;
        forced   = trig_word_i[44] | read_all_i;
        safe_now = safe_en_i && (trig_occ_i >= safe_thresh_i);
        sel_now  = forced ? {NCH{1'b1}} : (err_word_i[NCH-1:0] & ch_en_i);
    end

    assign trig_rd_o = start;
    assign err_rd_o  = start;

    // Zero-extend the captured map to whole payload words.
    always_comb begin
        map_ext          = '0;
        map_ext[NCH-1:0] = err_q[NCH-1:0];
    end

    raw_chan_pick #(.NCH(NCH), .IW(IW)) u_pick (
        .pend_i (pend),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    assign pop = (st == ST_DRAIN) && !out_full_i && sel_valid;

    raw_chan_mux #(.NCH(NCH), .IW(IW), .CHW(CHW)) u_mux (
        .ch_data_i   (ch_data_i),
        .ch_valid_i  (ch_valid_i),
        .idx_i       (cur),
        .pop_i       (pop),
        .sel_word_o  (sel_word),
        .sel_valid_o (sel_valid),
        .rd_o        (ch_rd_o)
    );

    raw_word_fmt #(.IW(IW)) u_fmt (
        .st_i        (st),
        .trig_i      (trig_q),
        .err_hi_i    (err_q[NCH+4:NCH]),
        .map_word_i  (map_ext[int'(map_i)*32 +: 32]),
        .chan_word_i (sel_word[31:0]),
        .cur_i       (cur),
        .eacc_i      (eacc),
        .cnt_i       (cnt),
        .word_o      (fmt_word),
        .char_o      (fmt_char)
    );

    // Decide whether this cycle writes a word.
    always_comb begin
        case (st)
            ST_HDR1, ST_HDR2, ST_MAP, ST_CTRL, ST_TRAIL: wr = !out_full_i;
            ST_DRAIN:                                    wr = !out_full_i && sel_valid;
            default:                                     wr = 1'b0;
        endcase
    end

    // Event sequencing and captured per-event context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            trig_q    <= '0;
            err_q     <= '0;
            pend      <= '0;
            cur       <= '0;
            safe_q    <= 1'b0;
            maponly_q <= 1'b0;
            map_i     <= '0;
            cnt       <= '0;
            eacc      <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        trig_q    <= trig_word_i;
                        err_q     <= err_word_i;
                        safe_q    <= safe_now;
                        pend      <= safe_now ? '0 : sel_now;
                        maponly_q <= !safe_now && (sel_now == '0);
                        map_i     <= '0;
                        cnt       <= '0;
                        st        <= ST_HDR1;
                    end
                end
                ST_HDR1: begin
                    if (!out_full_i) st <= ST_HDR2;
                end
                ST_HDR2: begin
                    if (!out_full_i) begin
                        if (safe_q)         st <= ST_TRAIL;
                        else if (maponly_q) st <= ST_MAP;
                        else                st <= ST_SCAN;
                    end
                end
                ST_MAP: begin
                    if (!out_full_i) begin
                        cnt <= cnt + 1'b1;
                        if (map_i == MIW'(MAPN - 1)) st <= ST_TRAIL;
                        else                         map_i <= map_i + 1'b1;
                    end
                end
                ST_SCAN: begin
                    if (pick_any) begin
                        cur            <= pick_idx;
                        pend[pick_idx] <= 1'b0;
                        eacc           <= '0;
                        st             <= ST_DRAIN;
                    end else begin
                        st <= ST_TRAIL;
                    end
                end
                ST_DRAIN: begin
                    if (!out_full_i) begin
                        if (sel_valid) begin
                            cnt  <= cnt + 1'b1;
                            eacc <= eacc | sel_word[CHW-1:32];
                        end else begin
                            st <= ST_CTRL;
                        end
                    end
                end
                ST_CTRL: begin
                    if (!out_full_i) begin
                        cnt <= cnt + 1'b1;
                        st  <= ST_SCAN;
                    end
                end
                ST_TRAIL: begin
                    if (!out_full_i) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output register: written word, or idle character when not writing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o  <= 1'b0;
            out_data_o   <= {24'd0, K_IDLE};
            out_char_o   <= 1'b1;
            frame_done_o <= 1'b0;
        end else begin
            out_valid_o  <= wr;
            out_data_o   <= wr ? fmt_word : {24'd0, K_IDLE};
            out_char_o   <= wr ? fmt_char : 1'b1;
            frame_done_o <= (st == ST_TRAIL) && !out_full_i;
        end
    end

    assign state_o = {4'd0, st};

endmodule

// File: rtl/raw_frame_builder_chk.sv
// Protocol checker for the raw event frame builder, attached by bind.
// Assumes the same NCH as the bound instance.
module raw_frame_builder_chk #(
    parameter int NCH = 49
) (
    input logic           clk,
    input logic           rst_n,
    input logic           trig_empty_i,
    input logic           err_empty_i,
    input logic           trig_rd_o,
    input logic [NCH-1:0] ch_valid_i,
    input logic [NCH-1:0] ch_rd_o,
    input logic           out_full_i,
    input logic [31:0]    out_data_o,
    input logic           out_char_o,
    input logic           out_valid_o,
    input logic           frame_done_o,
    input logic [7:0]     state_o
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [IW-1:0] rd_idx;
    logic          rd_any;
    logic [IW-1:0] last_idx;
    logic          seen;

    // Index of the channel being popped this cycle.
    always_comb begin
        rd_any = |ch_rd_o;
        rd_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (ch_rd_o[i]) rd_idx = IW'(i);
        end
    end

    // Remember the last channel popped within the current event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_idx <= '0;
            seen     <= 1'b0;
        end else if (frame_done_o) begin
            last_idx <= '0;
            seen     <= 1'b0;
        end else if (rd_any) begin
            last_idx <= rd_idx;
            seen     <= 1'b1;
        end
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rd_o |-> (!trig_empty_i && !err_empty_i && !out_full_i)); // R2
    AST_POP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rd_o |-> (state_o == 8'd0)); // R13
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && seen) |-> (rd_idx >= last_idx)); // R4
    AST_IDLE_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (out_char_o && out_data_o == 32'h0000_00BC)); // R9
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out_full_i |=> !out_valid_o); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o); // R11
    AST_DONE_ON_TRAILER: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (out_valid_o && out_char_o && out_data_o[7:0] == 8'hDC)); // R11
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_rd_o)); // R12
    AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rd_o & ~ch_valid_i) == '0); // R12

endmodule

bind raw_frame_builder raw_frame_builder_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_empty_i (trig_empty_i),
    .err_empty_i  (err_empty_i),
    .trig_rd_o    (trig_rd_o),
    .ch_valid_i   (ch_valid_i),
    .ch_rd_o      (ch_rd_o),
    .out_full_i   (out_full_i),
    .out_data_o   (out_data_o),
    .out_char_o   (out_char_o),
    .out_valid_o  (out_valid_o),
    .frame_done_o (frame_done_o),
    .state_o      (state_o)
);

// File: tb/test_raw_frame_builder.sv
module test_raw_frame_builder;

    localparam int NCH  = 49;
    localparam int OCCW = 13;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [46:0]        trig_word = '0;
    logic               trig_empty = 1'b1;
    logic [OCCW-1:0]    occ = '0;
    logic               trig_rd;
    logic [NCH+4:0]     err_word = '0;
    logic               err_empty = 1'b1;
    logic               err_rd;
    logic [NCH*36-1:0]  ch_data;
    logic [NCH-1:0]     ch_valid;
    logic [NCH-1:0]     ch_en = '1;
    logic [NCH-1:0]     ch_rd;
    logic               read_all = 1'b0;
    logic               safe_en = 1'b0;
    logic [OCCW-1:0]    thresh = '0;
    logic               out_full;
    logic [31:0]        out_data;
    logic               out_char;
    logic               out_valid;
    logic               frame_done;
    logic [7:0]         state;

    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    raw_frame_builder #(.NCH(NCH), .OCCW(OCCW)) i_raw_frame_builder (
        .clk(clk), .rst_n(rst_n),
        .trig_word_i(trig_word), .trig_empty_i(trig_empty), .trig_occ_i(occ),
        .trig_rd_o(trig_rd),
        .err_word_i(err_word), .err_empty_i(err_empty), .err_rd_o(err_rd),
        .ch_data_i(ch_data), .ch_valid_i(ch_valid), .ch_en_i(ch_en), .ch_rd_o(ch_rd),
        .read_all_i(read_all), .safe_en_i(safe_en), .safe_thresh_i(thresh),
        .out_full_i(out_full), .out_data_o(out_data), .out_char_o(out_char),
        .out_valid_o(out_valid), .frame_done_o(frame_done), .state_o(state)
    );

    // Channel FIFO models: len words per load, popped on ch_rd.
    int        len  [NCH];
    int        base [NCH];
    int        pops [NCH];
    logic [3:0] cerr [NCH];

    initial begin
        for (int c = 0; c < NCH; c++) begin
            len[c] = 0; base[c] = 0; pops[c] = 0; cerr[c] = 4'((c * 5 + 3) % 16);
        end
    end

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (ch_rd[c]) pops[c] <= pops[c] + 1;
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            ch_valid[c] = (len[c] - (pops[c] - base[c])) > 0;
            ch_data[c*36 +: 36] = {cerr[c], 8'(c), 8'h5A, 16'(len[c] - (pops[c] - base[c]))};
        end
    end

    // Output FIFO full driver: held level or pseudo-random stalls.
    bit       stall_on = 1'b0;
    logic     hold_full = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    initial begin
        out_full = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_full = stall_on ? (lfsr[0] & lfsr[2]) : hold_full;
        end
    end

    // Output monitor.
    logic [32:0] got_q[$];
    logic [32:0] exp_q[$];
    int   exp_pop [NCH];
    int   done_cnt = 0;
    int   rd_cnt = 0;
    int   mon_bad = 0;
    logic full_at_edge = 1'b0;

    always @(posedge clk) full_at_edge <= out_full;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                got_q.push_back({out_char, out_data});
                if (full_at_edge) begin
                    mon_bad++;
                    $display("FAIL R10: write while full act=%h exp=no write", out_data);
                end
            end else if (out_data != 32'h0000_00BC || !out_char) begin
                mon_bad++;
                $display("FAIL R9: idle output act=%0b_%h exp=1_000000bc", out_char, out_data);
            end
            if (frame_done) begin
                done_cnt++;
                if (!(out_valid && out_char && out_data[7:0] == 8'hDC)) begin
                    mon_bad++;
                    $display("FAIL R11: done not on trailer act=%h exp=..dc", out_data);
                end
            end
            if (trig_rd || err_rd) rd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    // Expected event from the requirements.
    function automatic void build_exp();
        logic [NCH-1:0] sel;
        int cnt;
        logic [3:0] e;
        exp_q.delete();
        for (int c = 0; c < NCH; c++) exp_pop[c] = 0;
        exp_q.push_back({1'b1, 9'd0, trig_word[46:44], trig_word[43:32], 8'h7C});
        exp_q.push_back({1'b0, trig_word[31:0]});
        cnt = 0;
        if (!(safe_en && occ >= thresh)) begin
            sel = (trig_word[44] || read_all) ? '1 : (err_word[NCH-1:0] & ch_en);
            if (sel == '0) begin
                exp_q.push_back({1'b0, err_word[31:0]});
                exp_q.push_back({1'b0, 15'd0, err_word[48:32]});
                cnt = 2;
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (sel[c]) begin
                        e = 4'd0;
                        for (int k = len[c]; k >= 1; k--) begin
                            exp_q.push_back({1'b0, 8'(c), 8'h5A, 16'(k)});
                            e = e | cerr[c];
                            cnt++;
                        end
                        exp_q.push_back({1'b0, 20'd0, e, 2'd0, 6'(c)});
                        cnt++;
                        exp_pop[c] = len[c];
                    end
                end
            end
        end
        exp_q.push_back({1'b1, 3'd0, err_word[53], err_word[52], err_word[51:49],
                         16'(cnt), 8'hDC});
    endfunction

    // Present one trigger and error record, collect the event, compare.
    task automatic run_frame(input string req);
        int d0, m0, t;
        bit ok;
        int first;
        build_exp();
        got_q.delete();
        d0 = done_cnt;
        m0 = mon_bad;
        for (int c = 0; c < NCH; c++) base[c] = pops[c];
        @(posedge clk); #1;
        trig_empty = 1'b0;
        err_empty  = 1'b0;
        t = 0;
        forever begin
            @(negedge clk);
            if (trig_rd) break;
            t++;
            if (t > 2000) break;
        end
        chk(trig_rd && err_rd, "R2", "both FIFOs popped together", {62'd0, trig_rd, err_rd}, 64'h3);
        @(posedge clk); #1;
        trig_empty = 1'b1;
        err_empty  = 1'b1;
        @(negedge clk);
        chk(state != 8'd0, "R13", "state busy after pop", 64'(state), 64'h1);
        t = 0;
        while (done_cnt == d0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        chk(state == 8'd0, "R13", "state idle after event", 64'(state), 64'h0);
        ok = (got_q.size() == exp_q.size());
        first = -1;
        if (ok) begin
            for (int i = 0; i < got_q.size(); i++) begin
                if (got_q[i] !== exp_q[i] && first < 0) first = i;
            end
            ok = (first < 0);
        end
        if (got_q.size() != exp_q.size())
            chk(1'b0, req, "event length", 64'(got_q.size()), 64'(exp_q.size()));
        else if (first >= 0)
            chk(1'b0, req, $sformatf("event word %0d", first), 64'(got_q[first]), 64'(exp_q[first]));
        else
            chk(1'b1, req, "event words", 0, 0);
        ok = 1'b1;
        first = -1;
        for (int c = 0; c < NCH; c++) begin
            if ((pops[c] - base[c]) != exp_pop[c] && first < 0) first = c;
        end
        if (first >= 0)
            chk(1'b0, "R12", $sformatf("pops of channel %0d", first),
                64'(pops[first] - base[first]), 64'(exp_pop[first]));
        else
            chk(1'b1, "R12", "channel pops", 0, 0);
        chk(done_cnt == d0 + 1, "R11", "one done pulse", 64'(done_cnt - d0), 64'd1);
        chk(mon_bad == m0, "R10", "monitor clean during event", 64'(mon_bad - m0), 64'd0);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run hung act=timeout exp=finish");
        report();
        $finish;
    end

    initial begin
        int r0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!out_valid && out_data == 32'hBC && out_char && !frame_done && state == 0,
            "R1", "reset outputs", {29'd0, out_valid, out_char, frame_done, out_data}, 64'h0_0000_0002_0000_00BC);
        chk(!trig_rd && !err_rd && ch_rd == '0, "R1", "no reads after reset",
            {62'd0, trig_rd, err_rd}, 64'd0);

        // R2: only one FIFO ready, then output full
        r0 = rd_cnt;
        @(posedge clk); #1 trig_empty = 1'b0;
        repeat (8) @(negedge clk);
        chk(rd_cnt == r0 && state == 0, "R2", "no start with error FIFO empty", 64'(rd_cnt - r0), 64'd0);
        @(posedge clk); #1 trig_empty = 1'b1; err_empty = 1'b0;
        repeat (8) @(negedge clk);
        chk(rd_cnt == r0 && state == 0, "R2", "no start with trigger FIFO empty", 64'(rd_cnt - r0), 64'd0);
        hold_full = 1'b1;
        @(posedge clk); #1 trig_empty = 1'b0;
        repeat (8) @(negedge clk);
        chk(rd_cnt == r0 && state == 0, "R2", "no start while output full", 64'(rd_cnt - r0), 64'd0);
        @(posedge clk); #1 trig_empty = 1'b1; err_empty = 1'b1;
        hold_full = 1'b0;
        repeat (3) @(posedge clk);

        // R5, R3, R8: no errors -> map-only event
        trig_word = {1'b1, 1'b0, 1'b0, 12'hABC, 32'h1234_5678};
        err_word  = {1'b1, 1'b1, 3'b101, 49'd0};
        for (int c = 0; c < NCH; c++) len[c] = 2;
        run_frame("R5");

        // R4, R5: errors masked by enables -> map words only
        trig_word = {1'b0, 1'b1, 1'b0, 12'h00F, 32'hCAFE_0001};
        err_word  = '0;
        err_word[3] = 1'b1; err_word[40] = 1'b1; err_word[51:49] = 3'b010;
        ch_en = '1; ch_en[3] = 1'b0; ch_en[40] = 1'b0;
        run_frame("R4");
        ch_en = '1;

        // R4: single errored channel swept over every position
        for (int s = 0; s < NCH; s++) begin
            for (int c = 0; c < NCH; c++) len[c] = (c == s) ? (s % 4) : 2;
            trig_word = {3'b000, 12'(s), 32'(s * 1000 + 7)};
            err_word  = '0;
            err_word[s] = 1'b1;
            run_frame("R4");
        end

        // R4: several errors, ascending order regardless of bit pattern
        trig_word = {3'b100, 12'h321, 32'hDEAD_BEEF};
        err_word  = '0;
        err_word[47] = 1'b1; err_word[2] = 1'b1; err_word[30] = 1'b1;
        err_word[0] = 1'b1; err_word[48] = 1'b1; err_word[52] = 1'b1;
        for (int c = 0; c < NCH; c++) len[c] = (c * 3) % 5;
        run_frame("R4");

        // R6: privilege flag forces every channel
        trig_word = {3'b001, 12'h777, 32'h0000_0042};
        err_word  = '0;
        err_word[10] = 1'b1;
        ch_en = '0;
        for (int c = 0; c < NCH; c++) len[c] = c % 3;
        run_frame("R6");

        // R6, R10: read-all input with random output stalls
        trig_word = {3'b000, 12'h001, 32'h0000_0043};
        err_word  = '0;
        read_all  = 1'b1;
        stall_on  = 1'b1;
        for (int c = 0; c < NCH; c++) len[c] = (c + 1) % 4;
        run_frame("R10");
        read_all = 1'b0;
        ch_en    = '1;

        // R10: stalled selective event
        trig_word = {3'b000, 12'h0AA, 32'h0000_0044};
        err_word  = '0;
        err_word[5] = 1'b1; err_word[33] = 1'b1; err_word[48] = 1'b1;
        for (int c = 0; c < NCH; c++) len[c] = 3;
        run_frame("R10");
        stall_on = 1'b0;

        // R7: threshold exactly reached -> empty event, even with privilege
        safe_en = 1'b1;
        thresh  = 13'd100;
        occ     = 13'd100;
        trig_word = {3'b001, 12'h055, 32'h0000_0100};
        err_word  = '0;
        err_word[7] = 1'b1; err_word[51:49] = 3'b111;
        run_frame("R7");

        // R7: one below threshold -> normal selective event
        occ = 13'd99;
        trig_word = {3'b000, 12'h056, 32'h0000_0101};
        run_frame("R7");

        // R7: safe mode off, occupancy far above threshold -> normal
        safe_en = 1'b0;
        occ     = 13'h1FFF;
        trig_word = {3'b000, 12'h057, 32'h0000_0102};
        run_frame("R7");

        report();
        $finish;
    end

endmodule